// File: doc/BRIEF.md
# SPI Serial Memory Slave

This block is the slave end of a small byte-addressed memory reached over a four-wire SPI link. Each selection of the device, marked by chip select going low, starts with one instruction byte. Depending on that byte the block then takes an address byte and data bytes, or it returns a status byte. The command set covers setting and clearing a write-enable latch, reading and writing status, and sequential reads and page-bounded writes against an internal register array. The array has a parameter-chosen size of 128, 256 or 512 bytes.

The SPI pins are sampled by a fast system clock through synchronisers. Serial clock edges are found from those samples, so the serial clock must stay well below a quarter of the system clock. A hold input pauses a transfer without deselecting the device. A write-protect input blocks status writes. A countdown after reset rejects every instruction until the supply can be trusted. A second countdown after each committed write models the busy time of the memory cells.

Top module: `spi_mem_slave`

## Requirements
- R1: For PWRUP_CYC system clocks after reset, every instruction is ignored. A status read gets no SO drive, and a set-latch instruction has no effect.
- R2: The first byte after chip select falls is the instruction, taken MSB first. Encodings: 0x06 sets the write-enable latch, 0x04 clears it, 0x05 reads status, 0x01 writes status, 0x03 reads and 0x02 writes. Any other byte is ignored until chip select rises.
- R3: The write-enable latch appears in status bit 1. It is set by 0x06, cleared by 0x04, and is 0 after reset.
- R4: Read and write take one address byte carrying address bits 7..0. With a 512-byte array, opcode bit 3 carries address bit 8, which gives 0x0B/0x0A for the upper half.
- R5: A write (0x02/0x0A) issued while the write-enable latch is clear changes no memory location.
- R6: When chip select rises after at least one write data byte or an accepted status byte, the latch clears and status bit 0 (write in progress) is 1 for WRITE_CYC clocks. This also holds when the final bit and the chip-select rise arrive together. While bit 0 is set, only the status read is obeyed.
- R7: A read keeps returning successive bytes, and the address wraps from the top of the array to 0.
- R8: Write data bytes go to successive addresses that wrap within an aligned page of 2^PAGE_W bytes.
- R9: A status write stores data bits 3:2 as the protect field in status bits 3:2. It is ignored while wp_n is low or while the latch is clear.
- R10: A protect field of 01 guards the top quarter of the array, 10 the top half and 11 all of it. Write bytes aimed at guarded addresses are dropped, but the write still clears the latch.
- R11: While hold is active (hold_n low, taken and released only while SCK is low), SCK edges are ignored and so_en is 0. The transfer resumes intact afterwards.
- R12: so_en is 0 while chip select is high and after reset. It is 1 only in the data phase of a read or status read.
- R13: SI is sampled on SCK rising edges and SO changes after SCK falling edges, with SCK idling either low (mode 0) or high (mode 3).
- R14: After reset every memory byte reads 0xFF and the status byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data into the block |
| so | output | 1 | Serial data out of the block |
| so_en | output | 1 | Output enable for so; 0 means so is tri-stated |
| wp_n | input | 1 | Write protect, active low, blocks status writes |
| hold_n | input | 1 | Hold, active low, pauses the transfer |

## Verification
The case that matters is a write commit landing in the same system clock as the completion of the last data byte. The bench raises chip select in the same timestep as the eighth rising SCK edge of the final byte, so that both pass through the synchronisers together. It then judges the outcome by reading status, which must show write in progress with the latch clear, and by reading the byte back after the busy time. A second overlap is a hold that freezes the bit counter in the middle of a read. The bench checks that the remaining bits and the following bytes come back unchanged after release.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam logic [7:0] OPC_SET_WEL  = 8'h06;
    localparam logic [7:0] OPC_CLR_WEL  = 8'h04;
    localparam logic [7:0] OPC_GET_STAT = 8'h05;
    localparam logic [7:0] OPC_PUT_STAT = 8'h01;
    localparam logic [7:0] OPC_READ     = 8'h03;
    localparam logic [7:0] OPC_WRITE    = 8'h02;
    localparam logic [7:0] OPC_HI_MASK  = 8'hF7;

    typedef enum logic [2:0] {
        C_NONE, C_SETWEL, C_CLRWEL, C_GETSTAT, C_PUTSTAT, C_READ, C_WRITE
    } cmd_e;

    typedef enum logic [2:0] {
        P_OPC, P_ADDR, P_RDATA, P_WDATA, P_SOUT, P_SIN, P_SKIP
    } phase_e;

    typedef struct packed {
        cmd_e cmd;
        logic a8;
    } dec_t;

    typedef struct packed {
        logic [1:0] bp;
        logic       wel;
        logic       wip;
    } stat_t;

    function automatic dec_t decode_opc(input logic [7:0] op, input logic wide);
        dec_t d;
        d.cmd = C_NONE;
        d.a8  = 1'b0;
        if (op == OPC_SET_WEL)
            d.cmd = C_SETWEL;
        else if (op == OPC_CLR_WEL)
            d.cmd = C_CLRWEL;
        else if (op == OPC_GET_STAT)
            d.cmd = C_GETSTAT;
        else if (op == OPC_PUT_STAT)
            d.cmd = C_PUTSTAT;
        else if ((op & OPC_HI_MASK) == OPC_READ && (wide || !op[3])) begin
            d.cmd = C_READ;
            d.a8  = op[3];
        end else if ((op & OPC_HI_MASK) == OPC_WRITE && (wide || !op[3])) begin
            d.cmd = C_WRITE;
            d.a8  = op[3];
        end
        return d;
    endfunction

    function automatic logic [7:0] stat_byte(input stat_t s);
        return {4'b0000, s.bp, s.wel, s.wip};
    endfunction

    // top2: the two most significant address bits
    function automatic logic is_guarded(input logic [1:0] top2, input logic [1:0] bp);
        case (bp)
            2'b01:   return top2 == 2'b11;
            2'b10:   return top2[1];
            2'b11:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/spim_sync.sv
module spim_sync #(
    parameter int          N       = 5,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [STAGES-1:0][N-1:0] st;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) st[s] <= RST_VAL;
        end else begin
            st[0] <= d;
            for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/spim_front.sv
module spim_front #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_s,
    input  logic              cs_s,
    input  logic              si_s,
    input  logic              hold_s,
    output logic              cs_rise,
    output logic              fall_tick,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              hold_act,
    output logic [CNT_W-1:0]  bit_cnt
);
    logic              sck_q;
    logic              cs_q;
    logic              rise_tick;
    logic [BYTE_W-2:0] sh;

    // An edge counts only if the device was selected in the previous cycle,
    // so a last edge arriving together with deselect is still taken.
    always_comb begin
        cs_rise   = cs_s && !cs_q;
        rise_tick = sck_s && !sck_q && !cs_q && !hold_act;
        fall_tick = !sck_s && sck_q && !cs_q && !hold_act;
        byte_done = rise_tick && (bit_cnt == CNT_W'(BYTE_W - 1));
        rx_byte   = {sh, si_s};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= 1'b0;
            cs_q     <= 1'b1;
            hold_act <= 1'b0;
            bit_cnt  <= '0;
            sh       <= '0;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_s;
            if (!sck_s)
                hold_act <= !hold_s;
            if (cs_s) begin
                bit_cnt <= '0;
            end else if (rise_tick) begin
                bit_cnt <= bit_cnt + 1'b1;
                sh      <= {sh[BYTE_W-3:0], si_s};
            end
        end
    end
endmodule

// File: rtl/spim_mem.sv
module spim_mem #(
    parameter int          ADDR_W = 9,
    parameter int          DATA_W = 8,
    parameter logic [DATA_W-1:0] ERASED = '1,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int PAGE_W    = 4,
    parameter int PWRUP_CYC = 250000,
    parameter int WRITE_CYC = 1250000,
    localparam int LOW_W  = (ADDR_W > 8) ? 8 : ADDR_W,
    localparam logic WIDE = (ADDR_W > 8),
    localparam int LOCK_W = $clog2(PWRUP_CYC + 1),
    localparam int BUSY_W = $clog2(WRITE_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_s,
    input  logic              wp_s,
    input  logic              hold_act,
    input  logic              cs_rise,
    input  logic              byte_done,
    input  logic              fall_tick,
    input  logic [7:0]        rx_byte,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic              so_bit,
    output logic              so_en,
    output logic              wel,
    output logic              wip,
    output logic [1:0]        bp,
    output logic              locked
);
    phase_e             phase;
    cmd_e               cmd;
    logic [ADDR_W-1:0]  addr;
    logic [ADDR_W-1:0]  join_addr;
    logic [ADDR_W-1:0]  page_next;
    logic [LOCK_W-1:0]  lock_cnt;
    logic [BUSY_W-1:0]  busy_cnt;
    logic               pend;
    logic               drive;
    logic [7:0]         tx;
    logic               commit;
    logic               guarded;
    dec_t               dec;
    stat_t              stat;

    always_comb begin
        dec    = decode_opc(rx_byte, WIDE);
        locked = (lock_cnt != '0);
        wip    = (busy_cnt != '0);

        stat.bp  = bp;
        stat.wel = wel;
        stat.wip = wip;

        join_addr = addr;
        join_addr[LOW_W-1:0] = rx_byte[LOW_W-1:0];

        page_next = addr;
        page_next[PAGE_W-1:0] = addr[PAGE_W-1:0] + 1'b1;

        mem_raddr = (phase == P_ADDR) ? join_addr : addr;
        guarded   = is_guarded(addr[ADDR_W-1 -: 2], bp);
        mem_we    = byte_done && (phase == P_WDATA) && !guarded;
        mem_waddr = addr;
        mem_wdata = rx_byte;

        commit = cs_rise && (pend || (byte_done && (phase == P_WDATA || phase == P_SIN)));
        so_en  = drive && !cs_s && !hold_act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= P_OPC;
            cmd      <= C_NONE;
            addr     <= '0;
            wel      <= 1'b0;
            bp       <= 2'b00;
            lock_cnt <= LOCK_W'(PWRUP_CYC);
            busy_cnt <= '0;
            pend     <= 1'b0;
            drive    <= 1'b0;
            tx       <= '0;
            so_bit   <= 1'b0;
        end else begin
            if (locked)
                lock_cnt <= lock_cnt - 1'b1;
            if (wip)
                busy_cnt <= busy_cnt - 1'b1;

            if (fall_tick) begin
                so_bit <= tx[7];
                tx     <= {tx[6:0], 1'b0};
            end

            if (byte_done) begin
                case (phase)
                    P_OPC: begin
                        phase <= P_SKIP;
                        cmd   <= dec.cmd;
                        if (!locked) begin
                            case (dec.cmd)
                                C_SETWEL:  if (!wip) wel <= 1'b1;
                                C_CLRWEL:  if (!wip) wel <= 1'b0;
                                C_GETSTAT: begin
                                    tx    <= stat_byte(stat);
                                    drive <= 1'b1;
                                    phase <= P_SOUT;
                                end
                                C_PUTSTAT: if (wel && wp_s && !wip) phase <= P_SIN;
                                C_READ: if (!wip) begin
                                    phase <= P_ADDR;
                                    addr  <= WIDE ? {dec.a8, {(ADDR_W-1){1'b0}}} : '0;
                                end
                                C_WRITE: if (wel && !wip) begin
                                    phase <= P_ADDR;
                                    addr  <= WIDE ? {dec.a8, {(ADDR_W-1){1'b0}}} : '0;
                                end
                                default: ;
                            endcase
                        end
                    end
                    P_ADDR: begin
                        if (cmd == C_READ) begin
                            tx    <= mem_rdata;
                            drive <= 1'b1;
                            addr  <= join_addr + 1'b1;
                            phase <= P_RDATA;
                        end else begin
                            addr  <= join_addr;
                            phase <= P_WDATA;
                        end
                    end
                    P_RDATA: begin
                        tx   <= mem_rdata;
                        addr <= addr + 1'b1;
                    end
                    P_WDATA: begin
                        pend <= 1'b1;
                        addr <= page_next;
                    end
                    P_SOUT: tx <= stat_byte(stat);
                    P_SIN: begin
                        bp    <= rx_byte[3:2];
                        pend  <= 1'b1;
                        phase <= P_SKIP;
                    end
                    default: ;
                endcase
            end

            if (commit) begin
                wel      <= 1'b0;
                busy_cnt <= BUSY_W'(WRITE_CYC);
            end

            if (cs_s) begin
                phase <= P_OPC;
                pend  <= 1'b0;
                drive <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
    parameter int ADDR_W    = 9,
    parameter int PAGE_W    = 4,
    parameter int PWRUP_CYC = 250000,
    parameter int WRITE_CYC = 1250000
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic so,
    output logic so_en,
    input  logic wp_n,
    input  logic hold_n
);
    localparam int PIN_N = 5;
    localparam logic [PIN_N-1:0] PIN_IDLE = 5'b11001;

    logic [PIN_N-1:0]  pins_s;
    logic              cs_s, sck_s, si_s, hold_s, wp_s;
    logic              cs_rise, fall_tick, byte_done, hold_act;
    logic [7:0]        rx_byte;
    logic [2:0]        bit_cnt;
    logic [ADDR_W-1:0] mem_raddr, mem_waddr;
    logic              mem_we;
    logic [7:0]        mem_wdata, mem_rdata;
    logic              wel, wip, locked;
    logic [1:0]        bp;

    spim_sync #(.N(PIN_N), .STAGES(2), .RST_VAL(PIN_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({wp_n, hold_n, si, sck, cs_n}),
        .q   (pins_s)
    );

    assign {wp_s, hold_s, si_s, sck_s, cs_s} = pins_s;

    spim_front #(.BYTE_W(8)) u_front (
        .clk       (clk),
        .rst       (rst),
        .sck_s     (sck_s),
        .cs_s      (cs_s),
        .si_s      (si_s),
        .hold_s    (hold_s),
        .cs_rise   (cs_rise),
        .fall_tick (fall_tick),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .hold_act  (hold_act),
        .bit_cnt   (bit_cnt)
    );

    spim_mem #(.ADDR_W(ADDR_W), .DATA_W(8), .ERASED(8'hFF)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    spim_ctrl #(
        .ADDR_W    (ADDR_W),
        .PAGE_W    (PAGE_W),
        .PWRUP_CYC (PWRUP_CYC),
        .WRITE_CYC (WRITE_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cs_s      (cs_s),
        .wp_s      (wp_s),
        .hold_act  (hold_act),
        .cs_rise   (cs_rise),
        .byte_done (byte_done),
        .fall_tick (fall_tick),
        .rx_byte   (rx_byte),
        .mem_rdata (mem_rdata),
        .mem_raddr (mem_raddr),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .so_bit    (so),
        .so_en     (so_en),
        .wel       (wel),
        .wip       (wip),
        .bp        (bp),
        .locked    (locked)
    );
endmodule

// File: rtl/spim_chk.sv
module spim_chk (
    input logic       clk,
    input logic       rst,
    input logic       wel,
    input logic       wip,
    input logic       locked,
    input logic       mem_we,
    input logic       wp_s,
    input logic       cs_s,
    input logic       hold_act,
    input logic [1:0] bp,
    input logic [2:0] bit_cnt
);
    AST_WEL_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> !locked) else $error("latch set during lockout"); // R1

    AST_COMMIT_CLEARS_WEL: assert property (@(posedge clk) disable iff (rst)
        $rose(wip) |-> ($past(wel) && !wel)) else $error("commit without latch"); // R6

    AST_WRITE_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (wel && !wip && !locked)) else $error("array write without latch"); // R5

    AST_BP_NEEDS_WP: assert property (@(posedge clk) disable iff (rst)
        !$stable(bp) |-> $past(wp_s)) else $error("protect field changed under wp"); // R9

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (hold_act && !cs_s) |=> ($stable(bit_cnt) || cs_s)) else $error("bit count moved in hold"); // R11
endmodule

bind spi_mem_slave spim_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wel      (wel),
    .wip      (wip),
    .locked   (locked),
    .mem_we   (mem_we),
    .wp_s     (wp_s),
    .cs_s     (cs_s),
    .hold_act (hold_act),
    .bp       (bp),
    .bit_cnt  (bit_cnt)
);

// File: tb/tb_spi_mem_slave.sv
module tb_spi_mem_slave;
    localparam int AW    = 9;
    localparam int DEPTH = 1 << AW;
    localparam int PWRUP = 1000;
    localparam int WCYC  = 600;
    localparam int H     = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1, hold_n = 1'b1;
    wire  so, so_en;

    int   n_chk = 0, n_err = 0;
    bit   mode3 = 1'b0;
    bit   en_seen;
    logic [7:0] exp_mem [DEPTH];
    bit   exp_wel = 1'b0;
    logic [1:0] exp_bp = 2'b00;
    logic [7:0] wbuf [16];

    always #2 clk = ~clk;

    spi_mem_slave #(.ADDR_W(AW), .PAGE_W(4), .PWRUP_CYC(PWRUP), .WRITE_CYC(WCYC)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
        .so(so), .so_en(so_en), .wp_n(wp_n), .hold_n(hold_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit exp_guard(input logic [8:0] a);
        case (exp_bp)
            2'd1:    return a[8:7] == 2'b11;
            2'd2:    return a[8];
            2'd3:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic sel();
        sck = mode3; tick(H); cs_n = 1'b0; tick(H);
    endtask

    task automatic desel();
        sck = mode3; tick(H); cs_n = 1'b1; tick(H);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input bit last_cs);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; si = tx[i]; tick(H);
            sck = 1'b1; rx[i] = so; en_seen |= so_en;
            if (i == 0 && last_cs) cs_n = 1'b1;
            tick(H);
        end
    endtask

    task automatic op1(input logic [7:0] opc);
        logic [7:0] r;
        sel(); xfer(opc, r, 1'b0); desel();
        if (opc == 8'h06) exp_wel = 1'b1;
        if (opc == 8'h04) exp_wel = 1'b0;
    endtask

    task automatic rdsr(output logic [7:0] st);
        logic [7:0] r;
        sel(); xfer(8'h05, r, 1'b0); en_seen = 1'b0; xfer(8'h00, st, 1'b0); desel();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] r;
        sel(); xfer(8'h01, r, 1'b0); xfer(v, r, 1'b0); desel();
        if (exp_wel && wp_n) begin exp_bp = v[3:2]; exp_wel = 1'b0; end
    endtask

    task automatic model_write(input logic [8:0] a, input int n);
        if (exp_wel && n > 0) begin
            for (int i = 0; i < n; i++) begin
                logic [8:0] p;
                p = {a[8:4], 4'(a[3:0] + 4'(i))};
                if (!exp_guard(p)) exp_mem[p] = wbuf[i];
            end
            exp_wel = 1'b0;
        end
    endtask

    task automatic do_write(input logic [8:0] a, input int n, input bit coincide);
        logic [7:0] r;
        sel();
        xfer({4'b0000, a[8], 3'b010}, r, 1'b0);
        xfer(a[7:0], r, 1'b0);
        for (int i = 0; i < n; i++) xfer(wbuf[i], r, coincide && (i == n - 1));
        if (coincide) begin sck = mode3; tick(H); end
        else desel();
        model_write(a, n);
    endtask

    task automatic read_check(input logic [8:0] a, input int n, input string tag);
        logic [7:0] r;
        sel();
        xfer({4'b0000, a[8], 3'b011}, r, 1'b0);
        xfer(a[7:0], r, 1'b0);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, r, 1'b0);
            check8(tag, r, exp_mem[9'(a + 9'(i))]);
        end
        desel();
    endtask

    task automatic wait_idle();
        tick(WCYC + 20);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] st;
        logic [7:0] r;
        int unsigned seed;
        seed = $urandom(32'd4242);
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        tick(5);
        rst = 1'b0;
        tick(2);
        check8("R12 reset so_en", {7'b0, so_en}, 8'h00);

        // R1: lockout, set-latch and status read inside the window
        op1(8'h06); exp_wel = 1'b0;
        rdsr(st);
        check8("R1 no drive in lockout", {7'b0, en_seen}, 8'h00);
        tick(PWRUP);
        rdsr(st);
        check8("R1 R14 status after lockout", st, 8'h00);
        check8("R12 drive during status read", {7'b0, en_seen}, 8'h01);
        read_check(9'h000, 3, "R14 erased");

        // R5: write without latch
        wbuf[0] = 8'h5A;
        do_write(9'h020, 1, 1'b0);
        wait_idle();
        read_check(9'h020, 1, "R5 write without latch");

        // R3
        op1(8'h06); rdsr(st); check8("R3 latch set", st, 8'h02);
        op1(8'h04); rdsr(st); check8("R3 latch cleared", st, 8'h00);

        // R4 / R6
        op1(8'h06);
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        do_write(9'h110, 3, 1'b0);
        rdsr(st); check8("R6 busy after commit", st, 8'h01);
        op1(8'h06); exp_wel = 1'b0;
        rdsr(st); check8("R6 latch ignored while busy", st, 8'h01);
        wait_idle();
        rdsr(st); check8("R6 busy over", st, 8'h00);
        read_check(9'h110, 3, "R4 upper half via opcode bit");
        read_check(9'h010, 1, "R4 lower half untouched");

        // R8 page wrap
        op1(8'h06);
        wbuf[0] = 8'hA0; wbuf[1] = 8'hA1; wbuf[2] = 8'hA2; wbuf[3] = 8'hA3;
        do_write(9'h03E, 4, 1'b0);
        wait_idle();
        read_check(9'h030, 16, "R8 page wrap");

        // R7 array wrap
        op1(8'h06); wbuf[0] = 8'h77; do_write(9'h1FF, 1, 1'b0); wait_idle();
        op1(8'h06); wbuf[0] = 8'h66; do_write(9'h000, 1, 1'b0); wait_idle();
        read_check(9'h1FE, 4, "R7 read wrap");

        // R9
        wp_n = 1'b0;
        op1(8'h06); wrsr(8'h0C);
        rdsr(st); check8("R9 ignored under wp", st, 8'h02);
        op1(8'h04); wp_n = 1'b1;
        wrsr(8'h08);
        rdsr(st); check8("R9 ignored without latch", st, 8'h00);
        op1(8'h06); wrsr(8'h04); wait_idle();
        rdsr(st); check8("R9 protect field", st, 8'h04);

        // R10
        op1(8'h06); wbuf[0] = 8'hAA; do_write(9'h1F0, 1, 1'b0); wait_idle();
        read_check(9'h1F0, 1, "R10 guarded dropped");
        rdsr(st); check8("R10 latch cleared", st, 8'h04);
        op1(8'h06); wbuf[0] = 8'hBB; do_write(9'h100, 1, 1'b0); wait_idle();
        read_check(9'h100, 1, "R10 unguarded written");
        op1(8'h06); wrsr(8'h00); wait_idle();

        // R11 hold inside a read
        sel();
        xfer(8'h0B, r, 1'b0);
        xfer(8'h10, r, 1'b0);
        sck = 1'b0; tick(H);
        hold_n = 1'b0; tick(6);
        check8("R11 tri-state in hold", {7'b0, so_en}, 8'h00);
        for (int k = 0; k < 3; k++) begin sck = 1'b1; tick(H); sck = 1'b0; tick(H); end
        hold_n = 1'b1; tick(6);
        for (int i = 0; i < 3; i++) begin
            xfer(8'h00, r, 1'b0);
            check8("R11 resumed read", r, exp_mem[9'h110 + 9'(i)]);
        end
        desel();
        check8("R12 tri-state when deselected", {7'b0, so_en}, 8'h00);

        // R6 coincident last bit and deselect
        op1(8'h06);
        wbuf[0] = 8'hC3; wbuf[1] = 8'h3C;
        do_write(9'h040, 2, 1'b1);
        rdsr(st); check8("R6 coincident deselect busy", st, 8'h01);
        wait_idle();
        read_check(9'h040, 2, "R6 coincident last byte kept");

        // R2 unknown opcode
        op1(8'h07);
        rdsr(st); check8("R2 unknown opcode", st, 8'h00);

        // R13 random traffic in both modes
        for (int k = 0; k < 16; k++) begin
            logic [8:0] a;
            int n;
            mode3 = 1'($urandom % 2);
            a = 9'($urandom % DEPTH);
            n = 1 + int'($urandom % 5);
            if ($urandom % 2 == 1) begin
                op1(8'h06);
                for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
                do_write(a, n, 1'b0);
                wait_idle();
            end
            read_check(a, n, "R13 random mode traffic");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule